// File: doc/BRIEF.md
# Sample-to-Host DMA Controller

This block drains converted samples from a show-ahead FIFO into host memory. Software enables the controller through a control word and arms a buffer by writing a length. The controller then issues one single-beat write request per sample at consecutive addresses above a latched buffer base. The buffer ends once the programmed number of words has been accepted.

If the status feature is on, one further write follows each finished buffer. That write carries a status word to a separate latched address. A write that the host side answers with an error stops the controller, and it stays stopped until software drops the enable. Dropping the enable does not cut a buffer short: the block finishes the transfer in progress and then holds itself in reset. A self-clearing reset bit aborts at once, and a self-clearing clear bit pulses a flush strobe towards the FIFO.

Top module: `smp_dma_ctrl`

## Requirements
- R1: In the control word, bit 18 enables the status write, bit 17 resets the controller, bit 16 enables it and bit 8 flushes the FIFO. `ctl_q` reads bits 18 and 16 as last written. Bits 17 and 8 and all other bits read 0. Writing bit 8 drives `fifo_clr` high for exactly the following cycle.
- R2: `state` reads 0 for idle, 1 for active, 2 for status write and 3 for error. A length write moves the controller from idle to active only when the enable is set and the length is nonzero. Any other length write in idle leaves the state at 0.
- R3: In active, `wr_req` is high exactly when the FIFO is not empty. Word k goes to `buf_base + 4*k`, using the base latched when the buffer was armed, and its data is the FIFO head. `fifo_rd` pulses on each accepted beat, that is, when `wr_ack` is high and `wr_err` is low.
- R4: A buffer terminates when the accepted word count `words_done` reaches the length. Termination sets the sticky `done_flag` and goes to state 2 if the status write is enabled, otherwise to 0.
- R5: In state 2, `wr_req` is high and `wr_addr` is the status base latched at arming. The data word has bit 31 = error flag, bit 30 = done flag, bit 29 = busy-write flag, bits 25:24 = state code and bits 15:0 = words transferred. All other bits are 0. An accepted beat returns the controller to idle.
- R6: A length write in state 1 or 2 has no effect on the transfer and sets the sticky `busy_flag`.
- R7: An acknowledge with `wr_err` high, in state 1 or 2, moves the controller to state 3 and sets `err_flag`. The controller stays in state 3 while the enable is set, and length writes there are ignored.
- R8: Clearing the enable during state 1 or 2 lets the transfer run to its end. While the enable is low in state 0 or 3, the controller is held in reset: state 0, count 0, all flags 0.
- R9: Writing bit 17 returns the controller to idle from any state at the next edge and clears the count and all flags. Bits 18 and 16 still take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_q | output | 32 | Control word read-back |
| len_wr | input | 1 | Buffer length write strobe |
| len_wdata | input | LW | Buffer length in words |
| buf_base | input | AW | Buffer base address, latched on arming |
| stat_base | input | AW | Status word address, latched on arming |
| fifo_clr | output | 1 | FIFO flush pulse |
| fifo_rd | output | 1 | FIFO pop |
| fifo_empty | input | 1 | FIFO empty |
| fifo_data | input | DW | FIFO head word |
| wr_req | output | 1 | Host write request |
| wr_addr | output | AW | Host write address |
| wr_data | output | DW | Host write data |
| wr_ack | input | 1 | Host write accepted or answered |
| wr_err | input | 1 | Host write failed, qualified by wr_ack |
| state | output | 2 | Controller state code |
| done_flag | output | 1 | Sticky buffer-terminated flag |
| busy_flag | output | 1 | Sticky length-write-while-busy flag |
| err_flag | output | 1 | Sticky error flag |
| words_done | output | LW | Words accepted in the current buffer |

## Verification
Buffers are driven with an immediate acknowledge and with an acknowledge on alternate cycles. This separates request holding from beat counting. A FIFO that runs dry mid-buffer shows that requests stall without skipping an address. Runs with the status write on and off show the extra beat and its word layout. Three ways of stopping a buffer are compared against one another: a failing acknowledge, a disable during a transfer and a reset-bit write during a transfer. Together they show which of the three ends the buffer, which lets it finish, and which clears the flags.

// File: rtl/smp_dma_ctrl.sv
module smp_dma_ctrl #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LW   = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_q,
  input  logic          len_wr,
  input  logic [LW-1:0] len_wdata,
  input  logic [AW-1:0] buf_base,
  input  logic [AW-1:0] stat_base,
  output logic          fifo_clr,
  output logic          fifo_rd,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  input  logic          wr_err,
  output logic [1:0]    state,
  output logic          done_flag,
  output logic          busy_flag,
  output logic          err_flag,
  output logic [LW-1:0] words_done
);
  localparam int PADW = DW - 8 - LW;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ACT = 2'd1, S_STS = 2'd2, S_ERR = 2'd3} st_t;

  st_t           st;
  logic          en_q, sten_q, clr_q;
  logic [LW-1:0] cnt, len_q;
  logic [AW-1:0] base_q, sbase_q;
  logic          done_q, busy_q, err_q;

  logic soft_rst, hold, beat, last;
  logic [DW-1:0] stat_word;

  assign soft_rst  = ctl_wr & ctl_wdata[17];
  assign hold      = ~en_q & (st == S_IDLE | st == S_ERR);
  assign beat      = wr_req & wr_ack;
  assign last      = (LW'(cnt + 1'b1) == len_q);
  assign stat_word = {err_q, done_q, busy_q, 3'b000, st, {PADW{1'b0}}, cnt};

  assign ctl_q      = {13'd0, sten_q, 1'b0, en_q, 16'd0};
  assign fifo_clr   = clr_q;
  assign wr_req     = (st == S_ACT & ~fifo_empty) | st == S_STS;
  assign wr_addr    = (st == S_STS) ? sbase_q : base_q + AW'(STEP) * AW'(cnt);
  assign wr_data    = (st == S_STS) ? stat_word : fifo_data;
  assign fifo_rd    = st == S_ACT & beat & ~wr_err;
  assign state      = st;
  assign done_flag  = done_q;
  assign busy_flag  = busy_q;
  assign err_flag   = err_q;
  assign words_done = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      en_q    <= 1'b0;
      sten_q  <= 1'b0;
      clr_q   <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
      base_q  <= '0;
      sbase_q <= '0;
      done_q  <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      clr_q <= ctl_wr & ctl_wdata[8];
      if (ctl_wr) begin
        en_q   <= ctl_wdata[16];
        sten_q <= ctl_wdata[18];
      end
      if (soft_rst | hold) begin
        st     <= S_IDLE;
        cnt    <= '0;
        done_q <= 1'b0;
        busy_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (len_wr & en_q & |len_wdata) begin
            st      <= S_ACT;
            cnt     <= '0;
            len_q   <= len_wdata;
            base_q  <= buf_base;
            sbase_q <= stat_base;
          end
          S_ACT: begin
            if (len_wr) busy_q <= 1'b1;
            if (beat) begin
              if (wr_err) begin
                st    <= S_ERR;
                err_q <= 1'b1;
              end else begin
                cnt <= LW'(cnt + 1'b1);
                if (last) begin
                  done_q <= 1'b1;
                  st     <= sten_q ? S_STS : S_IDLE;
                end
              end
            end
          end
          S_STS: begin
            if (len_wr) busy_q <= 1'b1;
            if (beat) begin
              if (wr_err) begin
                st    <= S_ERR;
                err_q <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smp_dma_ctrl_chk.sv
module smp_dma_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    state,
  input logic          wr_req,
  input logic          wr_ack,
  input logic          wr_err,
  input logic [AW-1:0] wr_addr,
  input logic          fifo_rd,
  input logic          fifo_empty,
  input logic          ctl_wr,
  input logic [31:0]   ctl_wdata,
  input logic [31:0]   ctl_q,
  input logic          err_flag,
  input logic          done_flag
);
  logic rst_wr;
  assign rst_wr = ctl_wr & ctl_wdata[17];

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack && !rst_wr) |=> (wr_req && $stable(wr_addr)));

  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (!fifo_empty && wr_ack && !wr_err));

  a_r2_no_arm_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !ctl_q[16]) |=> (state == 2'd0));

  a_r7_err_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && wr_err && !rst_wr) |=> (state == 2'd3 && err_flag));

  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && ctl_q[16] && !rst_wr) |=> (state == 2'd3));

  a_r4_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(wr_ack && !wr_err));
endmodule

bind smp_dma_ctrl smp_dma_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .wr_req(wr_req), .wr_ack(wr_ack),
  .wr_err(wr_err), .wr_addr(wr_addr), .fifo_rd(fifo_rd), .fifo_empty(fifo_empty),
  .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .err_flag(err_flag),
  .done_flag(done_flag)
);

// File: tb/sim_smp_dma_ctrl.sv
module sim_smp_dma_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_wr = 0, len_wr = 0, fifo_empty = 1, wr_ack = 0, wr_err = 0;
  logic [31:0] ctl_wdata = 0, fifo_data = 0, buf_base = 0, stat_base = 0;
  logic [15:0] len_wdata = 0;
  logic [31:0] ctl_q, wr_addr, wr_data;
  logic        fifo_clr, fifo_rd, wr_req, done_flag, busy_flag, err_flag;
  logic [1:0]  state;
  logic [15:0] words_done;

  smp_dma_ctrl u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  logic [31:0] fq[$];
  int  vectors = 0, fails = 0, cyc = 0, seq = 0;
  bit  ack_slow = 0, err_arm = 0, finished = 0;
  int  m_st = 0, m_cnt = 0, m_len = 0;
  bit  m_en = 0, m_sten = 0, m_clr = 0, m_done = 0, m_busy = 0, m_err = 0;
  longint m_base = 0, m_sbase = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin
      fq.push_back(32'hA000_0000 + 32'(seq));
      seq++;
    end
  endtask

  task automatic step(bit cw, logic [31:0] cd, bit lw, logic [15:0] ld);
    bit e_req, ack, err, e_rd;
    logic [31:0] e_word;
    ctl_wr = cw; ctl_wdata = cd; len_wr = lw; len_wdata = ld;
    fifo_empty = (fq.size() == 0);
    fifo_data  = fifo_empty ? 32'h0 : fq[0];
    e_req = (m_st == 1 && !fifo_empty) || m_st == 2;
    ack   = e_req && (!ack_slow || cyc[0]);
    err   = ack && err_arm;
    if (err) err_arm = 0;
    wr_ack = ack; wr_err = err;
    e_rd  = (m_st == 1) && ack && !err;
    e_word = {m_err, m_done, m_busy, 3'b000, 2'(m_st), 8'h00, 16'(m_cnt)};
    #1;
    chk("R1", "ctl_q", ctl_q, {13'd0, m_sten, 1'b0, m_en, 16'd0});
    chk("R1", "fifo_clr", fifo_clr, m_clr);
    chk("R2", "state", state, m_st);
    chk("R3", "wr_req", wr_req, e_req);
    chk("R3", "fifo_rd", fifo_rd, e_rd);
    chk("R4", "done_flag", done_flag, m_done);
    chk("R4", "words_done", words_done, m_cnt);
    chk("R6", "busy_flag", busy_flag, m_busy);
    chk("R7", "err_flag", err_flag, m_err);
    if (e_req && m_st == 1) begin
      chk("R3", "wr_addr", wr_addr, 32'(m_base + 4 * m_cnt));
      chk("R3", "wr_data", wr_data, fifo_data);
    end
    if (m_st == 2) begin
      chk("R5", "status addr", wr_addr, 32'(m_sbase));
      chk("R5", "status word", wr_data, e_word);
    end
    if (e_rd) void'(fq.pop_front());
    if (m_clr) fq.delete();
    m_clr = cw && cd[8];
    if ((cw && cd[17]) || (!m_en && (m_st == 0 || m_st == 3))) begin
      m_st = 0; m_cnt = 0; m_done = 0; m_busy = 0; m_err = 0;
    end else if (m_st == 0) begin
      if (lw && m_en && ld != 0) begin
        m_st = 1; m_cnt = 0; m_len = ld; m_base = buf_base; m_sbase = stat_base;
      end
    end else if (m_st == 1 || m_st == 2) begin
      if (lw) m_busy = 1;
      if (ack && err) begin
        m_st = 3; m_err = 1;
      end else if (ack && m_st == 2) begin
        m_st = 0;
      end else if (ack) begin
        m_cnt++;
        if (m_cnt == m_len) begin
          m_done = 1;
          m_st = m_sten ? 2 : 0;
        end
      end
    end
    if (cw) begin m_en = cd[16]; m_sten = cd[18]; end
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    chk("R1", "reset ctl_q", ctl_q, 0);
    chk("R2", "reset state", state, 0);
    chk("R3", "reset wr_req", wr_req, 0);
    @(negedge clk);
    rst_n = 1;
    idle(2);

    // R3 R4: plain buffer, immediate acknowledge
    buf_base = 32'h0000_1000; stat_base = 32'h0000_8000;
    step(1, 32'h0001_0000, 0, 0);
    push(4);
    step(0, 0, 1, 16'd4);
    idle(6);
    chk("R4", "done after buffer", done_flag, 1);

    // R2: length writes ignored when disabled or zero
    step(1, 32'h0000_0000, 0, 0);
    step(0, 0, 1, 16'd3);
    idle(2);
    chk("R2", "no arm when disabled", state, 0);
    step(1, 32'h0001_0000, 0, 0);
    step(0, 0, 1, 16'd0);
    idle(1);
    chk("R2", "no arm on zero length", state, 0);

    // R5 R6: status write, alternate acknowledge, length write while busy
    ack_slow = 1;
    buf_base = 32'h0000_2000; stat_base = 32'h0000_9000;
    step(1, 32'h0005_0000, 0, 0);
    push(3);
    step(0, 0, 1, 16'd3);
    idle(2);
    step(0, 0, 1, 16'd7);
    idle(8);
    chk("R6", "busy set", busy_flag, 1);
    chk("R5", "back to idle", state, 0);

    // R3: FIFO runs dry mid-buffer
    ack_slow = 0;
    step(1, 32'h0001_0000, 0, 0);
    buf_base = 32'h0000_3000;
    push(2);
    step(0, 0, 1, 16'd5);
    idle(5);
    push(3);
    idle(6);

    // R7: error on second beat, then held until disabled
    push(4);
    step(0, 0, 1, 16'd4);
    while (m_cnt < 1) idle(1);
    err_arm = 1;
    idle(4);
    chk("R7", "error state", state, 3);
    step(0, 0, 1, 16'd2);
    idle(2);
    chk("R7", "error sticky", state, 3);
    step(1, 32'h0000_0100, 0, 0);
    idle(2);
    chk("R8", "disabled error clears", state, 0);

    // R8: graceful disable
    step(1, 32'h0001_0000, 0, 0);
    push(1);
    step(0, 0, 1, 16'd3);
    idle(3);
    step(1, 32'h0000_0000, 0, 0);
    idle(2);
    chk("R8", "still active after disable", state, 1);
    push(2);
    idle(5);
    chk("R8", "idle and cleared", state, 0);
    chk("R8", "count cleared", words_done, 0);

    // R9: reset bit aborts mid-buffer, enable kept; R1 flush pulse
    ack_slow = 1;
    step(1, 32'h0001_0000, 0, 0);
    push(5);
    step(0, 0, 1, 16'd5);
    idle(3);
    step(1, 32'h0003_0000, 0, 0);
    #1;
    chk("R9", "aborted to idle", state, 0);
    chk("R9", "enable kept", ctl_q[16], 1);
    @(negedge clk);
    step(1, 32'h0001_0100, 0, 0);
    idle(3);
    chk("R1", "fifo flushed", fq.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule